// File: doc/BRIEF.md
# Burst-Capable Synchronous Static RAM

This block is a single-port synchronous RAM that holds 18-bit words, each split into two 9-bit byte lanes. The number of words is set by a parameter. Every input except the output-enable qualifier is captured on the rising clock edge: the address, the write data, the two active-low lane write enables, the active-low select, and three active-low burst strobes. One burst strobe starts a load from the processor side and one from the controller side. The third advances the burst.

A load captures a base address. A 2-bit beat counter then produces the two low address bits of a four-beat burst in interleaved order. The low bits equal the base bits XOR the count. Each continuation cycle either steps the count or repeats the current beat, which inserts a wait state. The two load strobes differ in priority and in whether they can write.

Read data for an access registered at one edge is presented during the next cycle. A drive flag replaces a real three-state pin. It shows when the data output would be driven.

Top module: `burst_sram`

## Requirements
- R1: A read registered at a rising edge shows the word at the accessed address on `rdata_o` during the following clock cycle. `rdrive_o` is high during that cycle while `out_en_n` is low.
- R2: When `cpu_load_n` and `sel_n` are both low at an edge, any burst in progress is dropped. A read is made at `addr_i`, beat count 0. `ctl_load_n` and both lane write enables are disregarded, and no memory word changes.
- R3: When `ctl_load_n` and `sel_n` are low and `cpu_load_n` is high, a new burst starts at `addr_i` with beat count 0. The access is a write of `wdata_i` at that edge if either lane enable is low. Otherwise it is a read.
- R4: In a processor-started burst, a following cycle with both load strobes high and a lane enable low writes `wdata_i` to the current burst address. A load cycle followed by a non-advancing write cycle therefore forms a two-cycle single write.
- R5: `sel_n` high with `ctl_load_n` low deselects the block. No access is made, nothing is driven in the next cycle, and the burst ends, so later continuation cycles do nothing until a new load. `sel_n` high with `ctl_load_n` high makes `cpu_load_n` have no effect, and `addr_i` is not loaded.
- R6: `sel_n` is examined only in cycles that could load a new base. A continuation cycle (both load strobes high, or `sel_n` high with `ctl_load_n` high) proceeds at either level of `sel_n`.
- R7: In a continuation cycle, `step_n` low increments the beat count before the access. `step_n` high reuses the current address.
- R8: The access address keeps the loaded upper bits, and its bits 1:0 equal base bits 1:0 XOR the beat count. The count runs 0, 1, 2, 3 and wraps back to 0, which returns the burst to its base address after four beats.
- R9: `wr_lo_n` low writes data bits 8:0 and `wr_hi_n` low writes data bits 17:9. The lane whose enable is high keeps its old contents.
- R10: `rdrive_o` is high only in the cycle after a read access and only while `out_en_n` is low. `out_en_n` acts without waiting for a clock edge. After a write, a deselect or an idle cycle, `rdrive_o` is low.
- R11: Synchronous active-high `rst` ends any burst and clears `rdrive_o`. A continuation cycle after reset makes no access. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | $clog2(DEPTH) | External word address |
| wdata_i | input | 18 | Write data, two 9-bit lanes |
| wr_lo_n | input | 1 | Lower lane (bits 8:0) write enable, active low |
| wr_hi_n | input | 1 | Upper lane (bits 17:9) write enable, active low |
| sel_n | input | 1 | Select, active low, examined at loads |
| cpu_load_n | input | 1 | Processor-side burst load strobe, active low, read only |
| ctl_load_n | input | 1 | Controller-side burst load strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| out_en_n | input | 1 | Asynchronous output-enable qualifier, active low |
| rdata_o | output | 18 | Read data of the previous cycle's access |
| rdrive_o | output | 1 | High when the read data would be driven |

## Verification
The checker follows the command decode on every cycle. It checks the following:
- a load always restarts the beat count and marks a burst active;
- a non-advancing continuation holds the count, and an advancing one adds exactly one modulo four;
- a deselect, a write or a high output enable never leaves the output driven.

Only the bench scenarios can show several properties. The interleaved address order for each base, the return to the base after four beats, and lane-selective writes need the bench. So does the fact that a processor load discards a concurrent write. The bench also shows that continuation after a deselect or a reset touches no word. Each of these needs a reference memory and readback across many cycles.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        CMD_CPU_LOAD = 2'd0,
        CMD_CTL_LOAD = 2'd1,
        CMD_DESEL    = 2'd2,
        CMD_CARRY    = 2'd3
    } cmd_e;

    typedef struct packed {
        op_e              op;
        logic [LANES-1:0] lane_we;
    } access_t;

    // Priority: processor load, controller load, deselect, continuation.
    function automatic cmd_e decode_cmd(input logic cpu_n, input logic ctl_n,
                                        input logic sel_n);
        if (!cpu_n && !sel_n)      return CMD_CPU_LOAD;
        else if (!ctl_n && !sel_n) return CMD_CTL_LOAD;
        else if (!ctl_n)           return CMD_DESEL;
        else                       return CMD_CARRY;
    endfunction

    // Interleaved beat order: base low bits XOR running count.
    function automatic logic [BEAT_W-1:0] beat_bits(input logic [BEAT_W-1:0] base,
                                                    input logic [BEAT_W-1:0] cnt);
        return base ^ cnt;
    endfunction

endpackage

// File: rtl/burst_seq.sv
module burst_seq
    import burst_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr_i,
    input  logic              cpu_load_n,
    input  logic              ctl_load_n,
    input  logic              sel_n,
    input  logic              step_n,
    input  logic [LANES-1:0]  wr_n,
    output logic [AW-1:0]     acc_addr,
    output access_t           acc,
    output logic [BEAT_W-1:0] cnt_q,
    output logic              active_q
);

    logic [AW-1:0]     base_q, base_nx;
    logic [BEAT_W-1:0] cnt_nx;
    logic              act_nx;
    logic              any_wr;
    cmd_e              cmd;

    assign cmd    = decode_cmd(cpu_load_n, ctl_load_n, sel_n);
    assign any_wr = ~&wr_n;

    always_comb begin
        base_nx     = base_q;
        cnt_nx      = cnt_q;
        act_nx      = active_q;
        acc.op      = OP_IDLE;
        acc.lane_we = '0;
        case (cmd)
            CMD_CPU_LOAD: begin
                base_nx = addr_i;
                cnt_nx  = '0;
                act_nx  = 1'b1;
                acc.op  = OP_READ;
            end
            CMD_CTL_LOAD: begin
                base_nx     = addr_i;
                cnt_nx      = '0;
                act_nx      = 1'b1;
                acc.op      = any_wr ? OP_WRITE : OP_READ;
                acc.lane_we = ~wr_n;
            end
            CMD_DESEL: begin
                act_nx = 1'b0;
            end
            default: begin
                if (active_q) begin
                    cnt_nx      = step_n ? cnt_q : cnt_q + 2'd1;
                    acc.op      = any_wr ? OP_WRITE : OP_READ;
                    acc.lane_we = ~wr_n;
                end
            end
        endcase
        acc_addr = {base_nx[AW-1:BEAT_W], beat_bits(base_nx[BEAT_W-1:0], cnt_nx)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else begin
            base_q   <= base_nx;
            cnt_q    <= cnt_nx;
            active_q <= act_nx;
        end
    end

endmodule

// File: rtl/sram_lanes.sv
module sram_lanes
    import burst_sram_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [AW-1:0]     addr,
    input  logic [LANES-1:0]  lane_we,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata_q
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g])
                store[addr] <= wdata[g*LANE_W +: LANE_W];
            if (rd_en)
                rdata_q[g*LANE_W +: LANE_W] <= store[addr];
        end
    end

endmodule

// File: rtl/read_stage.sv
module read_stage
    import burst_sram_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    input  logic out_en_n,
    output logic rdrive_o
);

    logic rd_valid_q;

    always_ff @(posedge clk) begin
        if (rst) rd_valid_q <= 1'b0;
        else     rd_valid_q <= (op == OP_READ);
    end

    assign rdrive_o = rd_valid_q & ~out_en_n;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(DEPTH)-1:0] addr_i,
    input  logic [17:0]              wdata_i,
    input  logic                     wr_lo_n,
    input  logic                     wr_hi_n,
    input  logic                     sel_n,
    input  logic                     cpu_load_n,
    input  logic                     ctl_load_n,
    input  logic                     step_n,
    input  logic                     out_en_n,
    output logic [17:0]              rdata_o,
    output logic                     rdrive_o
);

    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0]     acc_addr;
    access_t           acc;
    logic [BEAT_W-1:0] seq_cnt;
    logic              seq_active;

    burst_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (addr_i),
        .cpu_load_n (cpu_load_n),
        .ctl_load_n (ctl_load_n),
        .sel_n      (sel_n),
        .step_n     (step_n),
        .wr_n       ({wr_hi_n, wr_lo_n}),
        .acc_addr   (acc_addr),
        .acc        (acc),
        .cnt_q      (seq_cnt),
        .active_q   (seq_active)
    );

    sram_lanes #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk     (clk),
        .addr    (acc_addr),
        .lane_we (acc.lane_we),
        .rd_en   (acc.op == OP_READ),
        .wdata   (wdata_i),
        .rdata_q (rdata_o)
    );

    read_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .op       (acc.op),
        .out_en_n (out_en_n),
        .rdrive_o (rdrive_o)
    );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int AW = 10
) (
    input logic       clk,
    input logic       rst,
    input logic       sel_n,
    input logic       cpu_load_n,
    input logic       ctl_load_n,
    input logic       step_n,
    input logic       wr_lo_n,
    input logic       wr_hi_n,
    input logic       out_en_n,
    input logic       rdrive_o,
    input logic [1:0] seq_cnt,
    input logic       seq_active
);

    logic carry_cyc;
    assign carry_cyc = ctl_load_n && (cpu_load_n || sel_n);

    // R2, R3: any load restarts the beat count and opens a burst
    p_load_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && (!cpu_load_n || !ctl_load_n)) |=> (seq_cnt == 2'd0 && seq_active));

    // R2: a processor load yields a read whatever the write enables
    p_cpu_read_r2: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !cpu_load_n) |=> (rdrive_o == !out_en_n));

    // R3: a controller write start leaves the output undriven
    p_ctl_write_r3: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && cpu_load_n && !ctl_load_n && (!wr_lo_n || !wr_hi_n)) |=> !rdrive_o);

    // R5: deselect drives nothing and ends the burst
    p_desel_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_n && !ctl_load_n) |=> (!rdrive_o && !seq_active));

    // R7: a held advance strobe keeps the beat
    p_suspend_r7: assert property (@(posedge clk) disable iff (rst)
        (seq_active && carry_cyc && step_n) |=> $stable(seq_cnt));

    // R8: an advancing beat adds one modulo four
    p_step_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (seq_active && carry_cyc && !step_n) |=> (seq_cnt == $past(seq_cnt) + 2'd1));

    // R10: output enable high never leaves data driven
    p_oe_gate_r10: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !rdrive_o);

    // R11: continuation with no burst open makes no read
    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!seq_active && carry_cyc) |=> !rdrive_o);

endmodule

bind burst_sram burst_sram_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_n      (sel_n),
    .cpu_load_n (cpu_load_n),
    .ctl_load_n (ctl_load_n),
    .step_n     (step_n),
    .wr_lo_n    (wr_lo_n),
    .wr_hi_n    (wr_hi_n),
    .out_en_n   (out_en_n),
    .rdrive_o   (rdrive_o),
    .seq_cnt    (seq_cnt),
    .seq_active (seq_active)
);

// File: tb/tb_burst_sram.sv
`timescale 1ns/100ps
module tb_burst_sram;

    localparam int DEPTH = 1024;
    localparam int AW    = 10;
    localparam int NVEC  = 28;

    // row: req[49:46] ctrl{cpu,ctl,sel,step,wlo,whi}[45:40] addr[39:30]
    //      wdata[29:12] kind[11:10] (0 none,1 read,2 write) expected addr[9:0]
    localparam logic [49:0] VEC [NVEC] = '{
        {4'd2,  6'b000100, 10'h005, 18'h3FFFF, 2'd1, 10'h005}, // R2 cpu load wins
        {4'd8,  6'b110011, 10'h3FF, 18'h00000, 2'd1, 10'h004}, // R8 beat 1
        {4'd7,  6'b110111, 10'h3FF, 18'h00000, 2'd1, 10'h004}, // R7 wait state
        {4'd8,  6'b110011, 10'h3FF, 18'h00000, 2'd1, 10'h007}, // R8 beat 2
        {4'd6,  6'b111011, 10'h3FF, 18'h00000, 2'd1, 10'h006}, // R6 sel high ignored
        {4'd8,  6'b110011, 10'h3FF, 18'h00000, 2'd1, 10'h005}, // R8 wrap
        {4'd5,  6'b011011, 10'h00A, 18'h00000, 2'd1, 10'h004}, // R5 cpu ignored
        {4'd3,  6'b100111, 10'h202, 18'h00000, 2'd1, 10'h202}, // R3 ctl read
        {4'd8,  6'b110011, 10'h000, 18'h00000, 2'd1, 10'h203}, // R8 upper kept
        {4'd8,  6'b110011, 10'h000, 18'h00000, 2'd1, 10'h200}, // R8
        {4'd9,  6'b100101, 10'h00C, 18'h2AAAA, 2'd2, 10'h00C}, // R9 lo lane
        {4'd3,  6'b110000, 10'h000, 18'h15555, 2'd2, 10'h00D}, // R3 burst write
        {4'd9,  6'b110110, 10'h000, 18'h3FE00, 2'd2, 10'h00D}, // R9 hi lane
        {4'd9,  6'b100111, 10'h00C, 18'h00000, 2'd1, 10'h00C}, // R9 readback
        {4'd9,  6'b110011, 10'h000, 18'h00000, 2'd1, 10'h00D}, // R9 readback
        {4'd2,  6'b010111, 10'h009, 18'h00000, 2'd1, 10'h009}, // R2 load
        {4'd4,  6'b110100, 10'h000, 18'h0BEEF, 2'd2, 10'h009}, // R4 single write
        {4'd5,  6'b101111, 10'h000, 18'h00000, 2'd0, 10'h000}, // R5 deselect
        {4'd5,  6'b110000, 10'h3FF, 18'h11111, 2'd0, 10'h000}, // R5 burst ended
        {4'd4,  6'b100111, 10'h009, 18'h00000, 2'd1, 10'h009}, // R4 readback
        {4'd5,  6'b001111, 10'h001, 18'h00000, 2'd0, 10'h000}, // R5 cpu+ctl, sel high
        {4'd2,  6'b000100, 10'h003, 18'h22222, 2'd1, 10'h003}, // R2 no write
        {4'd2,  6'b100111, 10'h003, 18'h00000, 2'd1, 10'h003}, // R2 unchanged
        {4'd8,  6'b100111, 10'h00B, 18'h00000, 2'd1, 10'h00B}, // R8 base 3
        {4'd8,  6'b110011, 10'h000, 18'h00000, 2'd1, 10'h00A}, // R8
        {4'd8,  6'b110011, 10'h000, 18'h00000, 2'd1, 10'h009}, // R8
        {4'd8,  6'b110011, 10'h000, 18'h00000, 2'd1, 10'h008}, // R8
        {4'd1,  6'b110011, 10'h000, 18'h00000, 2'd1, 10'h00B}  // R1 back to base
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_i;
    logic [17:0]   wdata_i;
    logic          wr_lo_n, wr_hi_n, sel_n, cpu_load_n, ctl_load_n, step_n, out_en_n;
    logic [17:0]   rdata_o;
    logic          rdrive_o;

    logic [17:0] refmem [DEPTH];
    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_sram #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .addr_i(addr_i), .wdata_i(wdata_i),
        .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .sel_n(sel_n),
        .cpu_load_n(cpu_load_n), .ctl_load_n(ctl_load_n), .step_n(step_n),
        .out_en_n(out_en_n), .rdata_o(rdata_o), .rdrive_o(rdrive_o)
    );

    task automatic drive(input logic [5:0] c, input logic [AW-1:0] a, input logic [17:0] d);
        {cpu_load_n, ctl_load_n, sel_n, step_n, wr_lo_n, wr_hi_n} = c;
        addr_i  = a;
        wdata_i = d;
    endtask

    task automatic check(input bit ok, input string req, input logic [17:0] act,
                         input logic [17:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ref_write(input logic [AW-1:0] a, input logic lo_n, input logic hi_n,
                             input logic [17:0] d);
        if (!lo_n) refmem[a][8:0]  = d[8:0];
        if (!hi_n) refmem[a][17:9] = d[17:9];
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        out_en_n = 1'b0;
        rst = 1'b1;
        drive(6'b111111, '0, '0);
        repeat (3) @(negedge clk);
        // R11: reset leaves nothing driven
        check(rdrive_o == 1'b0, "R11 reset drive", {17'd0, rdrive_o}, 18'd0);
        rst = 1'b0;
        tick();
        // R11: continuation with no burst open does not drive
        drive(6'b110011, 10'h001, '0);
        tick();
        check(rdrive_o == 1'b0, "R11 idle after reset", {17'd0, rdrive_o}, 18'd0);

        // prefill through controller single writes
        for (int i = 0; i < 20; i++) begin
            logic [AW-1:0] a;
            logic [17:0]   d;
            a = (i < 16) ? AW'(i) : AW'(10'h200 + i - 16);
            d = 18'(i * 18'h0A5B + 18'h01234);
            drive(6'b100100, a, d);
            ref_write(a, 1'b0, 1'b0, d);
            tick();
        end

        for (int v = 0; v < NVEC; v++) begin
            logic [49:0]   r;
            logic [AW-1:0] ea;
            string         tag;
            r   = VEC[v];
            ea  = r[9:0];
            tag = $sformatf("R%0d vec%0d", r[49:46], v);
            drive(r[45:40], r[39:30], r[29:12]);
            tick();
            case (r[11:10])
                2'd1: begin
                    check(rdrive_o == 1'b1, {tag, " drive"}, {17'd0, rdrive_o}, 18'd1);
                    check(rdata_o === refmem[ea], {tag, " data"}, rdata_o, refmem[ea]);
                end
                2'd2: begin
                    ref_write(ea, r[41], r[40], r[29:12]);
                    check(rdrive_o == 1'b0, {tag, " write drive"}, {17'd0, rdrive_o}, 18'd0);
                end
                default:
                    check(rdrive_o == 1'b0, {tag, " none drive"}, {17'd0, rdrive_o}, 18'd0);
            endcase
        end

        // R10: output enable acts between edges
        drive(6'b100111, 10'h002, '0);
        tick();
        out_en_n = 1'b1;
        #0.5;
        check(rdrive_o == 1'b0, "R10 oe high", {17'd0, rdrive_o}, 18'd0);
        out_en_n = 1'b0;
        #0.5;
        check(rdrive_o == 1'b1, "R10 oe low", {17'd0, rdrive_o}, 18'd1);
        check(rdata_o === refmem[2], "R1 data held", rdata_o, refmem[2]);

        // R11: reset mid-burst ends it; later continuation is idle
        drive(6'b111111, '0, '0);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        drive(6'b110011, '0, '0);
        tick();
        check(rdrive_o == 1'b0, "R11 burst cleared", {17'd0, rdrive_o}, 18'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule